// File: doc/BRIEF.md
# Serial EEPROM Page Write Sequencer

This block writes a run of 16-bit words into a serial EEPROM over a four-wire link: a serial clock, an active-low select, a data line into the memory and a data line out of it. The caller gives a word offset, a word count and a write-cycle delay, then pulses `start`. The block checks the request against the memory size. For each page it polls the memory's status byte until the memory is idle. It then sends a write-enable command on its own, followed by a write command carrying the byte address and the data. Write data is pulled one word at a time through a single-cycle request strobe.

A run that crosses a page boundary is split. The select line is raised after the last word of each page. The block waits the programmed number of cycles and opens a fresh transaction, with a new status poll, for the words that remain. The run ends with a one-cycle `done` pulse, and `fail` is high in that same cycle if the request was rejected or the memory stayed busy too long.

Top module: `eeprom_page_writer`

## Requirements
- R1: A request whose offset is at or above WORD_SIZE, or whose count is zero, or whose count exceeds WORD_SIZE minus offset is rejected. The reject is a `done` pulse with `fail` high. There is no select activity and no `dataReq`.
- R2: Each page transaction starts with status polls. Each poll is its own select window holding the read-status opcode 0x05 followed by 8 clocks of input. Polling repeats while status bit 0 is 1, and the other status bits are ignored.
- R3: If MAX_RETRY consecutive polls all report busy, the block raises select, pulses `done` with `fail` high and sends no write-enable.
- R4: Once the memory reports idle, the write-enable opcode 0x06 is sent alone in one select window. The write opcode 0x02 then opens the next window.
- R5: With ADDR_BITS equal to 8, a page whose first word index is 128 or more gets bit 3 (0x08) set in its write opcode, giving 0x0A.
- R6: The write opcode is followed by the byte address. The byte address is twice the word index, truncated to ADDR_BITS bits.
- R7: Each data word is fetched with a one-cycle `dataReq`, and `wrData` is sampled in that cycle. The low byte is sent before the high byte. The total number of requests equals the count.
- R8: After a word whose following byte address is a multiple of PAGE_BYTES, the write window closes. The remaining words go out in a new transaction that begins again with R2.
- R9: Every field goes out most significant bit first. The data line to the memory is low outside outgoing fields. The serial clock is low whenever select is high. Status bits are sampled while the clock is high.
- R10: After each write window, select stays high for at least `wcDelay` clock cycles before the next poll or before `done`.
- R11: During and after reset, select is high, and the clock, the data line, `busy`, `done` and `fail` are low.
- R12: A successful run ends with exactly one `done` cycle with `fail` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Begin a write run, sampled while idle |
| offset | input | IDX_W | First word index |
| count | input | IDX_W | Number of words |
| wcDelay | input | DLY_W | Cycles to wait after each page |
| dataReq | output | 1 | One-cycle request for the next word |
| wrData | input | 16 | Word sampled while dataReq is high |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | High with done when the run failed |
| spiClk | output | 1 | Serial clock to the memory |
| spiCsN | output | 1 | Active-low memory select |
| spiMosi | output | 1 | Data to the memory |
| spiMiso | input | 1 | Data from the memory |

## Verification
A wrong control state appears on the link within one field time. A wrong opcode, address or byte order corrupts the bytes of the current select window. A wrong page-edge decision changes how many select windows there are and how long they are. A wrong retry count shows up as a wrong number of status windows before `done`. A stuck or skipped wait state changes the gap between the final select rise and `done` by whole cycles. A fetch fault changes the number of data requests.

// File: rtl/epw_pkg.sv
package epw_pkg;
  localparam int FIELD_W = 16;
  localparam int NBITS_W = 5;

  localparam logic [FIELD_W-1:0] OPC_STATUS = 16'h0005;
  localparam logic [FIELD_W-1:0] OPC_WREN   = 16'h0006;
  localparam logic [FIELD_W-1:0] OPC_WRITE  = 16'h0002;
  localparam logic [FIELD_W-1:0] OPC_HIADDR = 16'h0008;

  typedef enum logic [2:0] {
    OP_NONE, OP_SELECT, OP_DESELECT, OP_PULSE, OP_SHIFT_OUT, OP_SHIFT_IN
  } linkOp_e;

  typedef struct packed {
    logic               go;
    linkOp_e            op;
    logic [FIELD_W-1:0] val;
    logic [NBITS_W-1:0] nBits;
  } linkCmd_t;
endpackage

// File: rtl/epw_link.sv
module epw_link
  import epw_pkg::*;
#(
  parameter int CLK_DIV = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  linkCmd_t cmd,
  output logic     linkDone,
  output logic [7:0] rxByte,
  output logic     spiClk,
  output logic     spiCsN,
  output logic     spiMosi,
  input  logic     spiMiso
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_HIGH, PH_LOW, PH_CSHI, PH_CSLO, PH_HOLD
  } phase_e;

  phase_e             phase;
  logic [DIV_W-1:0]   divCnt;
  logic [NBITS_W-1:0] bitsLeft;
  logic [FIELD_W-1:0] shReg;
  logic [FIELD_W-1:0] aligned;
  logic               isRead;
  logic               phaseEnd;

  assign phaseEnd = (divCnt == DIV_W'(CLK_DIV - 1));

  // left-align the outgoing field so the MSB sits at the top
  always_comb aligned = cmd.val << (NBITS_W'(FIELD_W) - cmd.nBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      divCnt   <= '0;
      bitsLeft <= '0;
      shReg    <= '0;
      isRead   <= 1'b0;
      linkDone <= 1'b0;
      rxByte   <= '0;
      spiClk   <= 1'b0;
      spiCsN   <= 1'b1;
      spiMosi  <= 1'b0;
    end else begin
      linkDone <= 1'b0;
      if (phase == PH_IDLE) begin
        divCnt <= '0;
        if (cmd.go) begin
          case (cmd.op)
            OP_SELECT: begin
              spiCsN <= 1'b0;
              spiClk <= 1'b0;
              phase  <= PH_HOLD;
            end
            OP_DESELECT: begin
              spiCsN <= 1'b1;
              spiClk <= 1'b0;
              phase  <= PH_HOLD;
            end
            OP_PULSE: begin
              spiCsN <= 1'b1;
              phase  <= PH_CSHI;
            end
            OP_SHIFT_OUT: begin
              shReg    <= aligned;
              spiMosi  <= aligned[FIELD_W-1];
              bitsLeft <= cmd.nBits;
              isRead   <= 1'b0;
              phase    <= PH_SETUP;
            end
            OP_SHIFT_IN: begin
              shReg    <= '0;
              spiMosi  <= 1'b0;
              bitsLeft <= cmd.nBits;
              isRead   <= 1'b1;
              phase    <= PH_SETUP;
            end
            default: ;
          endcase
        end
      end else if (!phaseEnd) begin
        divCnt <= divCnt + 1'b1;
      end else begin
        divCnt <= '0;
        case (phase)
          PH_SETUP: begin
            spiClk <= 1'b1;
            phase  <= PH_HIGH;
          end
          PH_HIGH: begin
            spiClk <= 1'b0;
            if (isRead) rxByte <= {rxByte[6:0], spiMiso};
            phase <= PH_LOW;
          end
          PH_LOW: begin
            if (bitsLeft == NBITS_W'(1)) begin
              spiMosi  <= 1'b0;
              phase    <= PH_IDLE;
              linkDone <= 1'b1;
            end else begin
              bitsLeft <= bitsLeft - 1'b1;
              shReg    <= shReg << 1;
              spiMosi  <= shReg[FIELD_W-2];
              phase    <= PH_SETUP;
            end
          end
          PH_CSHI: begin
            spiCsN <= 1'b0;
            phase  <= PH_CSLO;
          end
          default: begin
            phase    <= PH_IDLE;
            linkDone <= 1'b1;
          end
        endcase
      end
    end
  end

  assert_sck_parked_R9: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> !spiClk);
  assert_mosi_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> !spiMosi);
  assert_cmd_when_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.go |-> (phase == PH_IDLE));
endmodule

// File: rtl/epw_ctrl.sv
module epw_ctrl
  import epw_pkg::*;
#(
  parameter int WORD_SIZE  = 256,
  parameter int IDX_W      = 16,
  parameter int OPC_BITS   = 8,
  parameter int ADDR_BITS  = 8,
  parameter int PAGE_BYTES = 32,
  parameter int MAX_RETRY  = 8,
  parameter int DLY_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] offset,
  input  logic [IDX_W-1:0] count,
  input  logic [DLY_W-1:0] wcDelay,
  output logic             dataReq,
  input  logic [15:0]      wrData,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output linkCmd_t         cmd,
  input  logic             linkDone,
  input  logic [7:0]       rxByte
);
  localparam int PAGE_WORDS = PAGE_BYTES / 2;
  localparam int RETRY_W    = $clog2(MAX_RETRY + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_SEL, S_POLL_OP, S_POLL_RD, S_RETRY_PULSE,
    S_WREN_PULSE, S_WREN, S_WR_PULSE, S_WR_OP, S_WR_ADDR, S_FETCH,
    S_WR_DATA, S_END, S_WAIT, S_FINISH
  } state_e;

  state_e             state;
  logic [IDX_W-1:0]   curWord, left, nextWord;
  logic [RETRY_W-1:0] retry;
  logic [DLY_W-1:0]   dlyCnt;
  logic [15:0]        dataWord;
  logic               issued, pendFail, badReq, pageEdge, hiAddr;
  logic [IDX_W:0]     byteAddr, roomLeft;
  logic [FIELD_W-1:0] addrField;

  assign nextWord = curWord + 1'b1;
  assign pageEdge = ((nextWord & IDX_W'(PAGE_WORDS - 1)) == '0);
  assign byteAddr = {curWord, 1'b0};
  assign roomLeft = (IDX_W+1)'(WORD_SIZE) - {1'b0, curWord};
  assign badReq   = ({1'b0, curWord} >= (IDX_W+1)'(WORD_SIZE)) ||
                    (left == '0) || ({1'b0, left} > roomLeft);

  always_comb begin
    addrField = '0;
    addrField[ADDR_BITS-1:0] = byteAddr[ADDR_BITS-1:0];
  end

  generate
    if (ADDR_BITS == 8) begin : g_hiaddr
      assign hiAddr = (curWord >= IDX_W'(128));
    end else begin : g_nohiaddr
      assign hiAddr = 1'b0;
    end
  endgenerate

  always_comb begin
    cmd.go    = 1'b0;
    cmd.op    = OP_NONE;
    cmd.val   = '0;
    cmd.nBits = '0;
    case (state)
      S_SEL: cmd.op = OP_SELECT;
      S_POLL_OP: begin
        cmd.op = OP_SHIFT_OUT; cmd.val = OPC_STATUS; cmd.nBits = NBITS_W'(OPC_BITS);
      end
      S_POLL_RD: begin
        cmd.op = OP_SHIFT_IN; cmd.nBits = NBITS_W'(8);
      end
      S_RETRY_PULSE, S_WREN_PULSE, S_WR_PULSE: cmd.op = OP_PULSE;
      S_WREN: begin
        cmd.op = OP_SHIFT_OUT; cmd.val = OPC_WREN; cmd.nBits = NBITS_W'(OPC_BITS);
      end
      S_WR_OP: begin
        cmd.op    = OP_SHIFT_OUT;
        cmd.val   = hiAddr ? (OPC_WRITE | OPC_HIADDR) : OPC_WRITE;
        cmd.nBits = NBITS_W'(OPC_BITS);
      end
      S_WR_ADDR: begin
        cmd.op = OP_SHIFT_OUT; cmd.val = addrField; cmd.nBits = NBITS_W'(ADDR_BITS);
      end
      S_WR_DATA: begin
        cmd.op    = OP_SHIFT_OUT;
        cmd.val   = {dataWord[7:0], dataWord[15:8]};
        cmd.nBits = NBITS_W'(16);
      end
      S_END: cmd.op = OP_DESELECT;
      default: ;
    endcase
    cmd.go = (cmd.op != OP_NONE) && !issued;
  end

  assign dataReq = (state == S_FETCH);
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_FINISH);
  assign fail    = done && pendFail;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      curWord  <= '0;
      left     <= '0;
      retry    <= '0;
      dlyCnt   <= '0;
      dataWord <= '0;
      issued   <= 1'b0;
      pendFail <= 1'b0;
    end else begin
      if (cmd.go)   issued <= 1'b1;
      if (linkDone) issued <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          curWord  <= offset;
          left     <= count;
          pendFail <= 1'b0;
          state    <= S_CHECK;
        end
        S_CHECK: begin
          if (badReq) begin
            pendFail <= 1'b1;
            state    <= S_FINISH;
          end else begin
            retry <= RETRY_W'(MAX_RETRY);
            state <= S_SEL;
          end
        end
        S_SEL:         if (linkDone) state <= S_POLL_OP;
        S_POLL_OP:     if (linkDone) state <= S_POLL_RD;
        S_POLL_RD: if (linkDone) begin
          if (!rxByte[0]) begin
            state <= S_WREN_PULSE;
          end else if (retry == RETRY_W'(1)) begin
            pendFail <= 1'b1;
            state    <= S_END;
          end else begin
            retry <= retry - 1'b1;
            state <= S_RETRY_PULSE;
          end
        end
        S_RETRY_PULSE: if (linkDone) state <= S_POLL_OP;
        S_WREN_PULSE:  if (linkDone) state <= S_WREN;
        S_WREN:        if (linkDone) state <= S_WR_PULSE;
        S_WR_PULSE:    if (linkDone) state <= S_WR_OP;
        S_WR_OP:       if (linkDone) state <= S_WR_ADDR;
        S_WR_ADDR:     if (linkDone) state <= S_FETCH;
        S_FETCH: begin
          dataWord <= wrData;
          state    <= S_WR_DATA;
        end
        S_WR_DATA: if (linkDone) begin
          curWord <= nextWord;
          left    <= left - 1'b1;
          state   <= ((left == IDX_W'(1)) || pageEdge) ? S_END : S_FETCH;
        end
        S_END: if (linkDone) begin
          dlyCnt <= '0;
          state  <= pendFail ? S_FINISH : S_WAIT;
        end
        S_WAIT: begin
          if (dlyCnt >= wcDelay) begin
            if (left == '0) begin
              state <= S_FINISH;
            end else begin
              retry <= RETRY_W'(MAX_RETRY);
              state <= S_SEL;
            end
          end else begin
            dlyCnt <= dlyCnt + 1'b1;
          end
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assert_single_done_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_fail_with_done_R1: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> done);
  assert_single_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataReq |=> !dataReq);
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
  import epw_pkg::*;
#(
  parameter int WORD_SIZE  = 256,
  parameter int IDX_W      = 16,
  parameter int OPC_BITS   = 8,
  parameter int ADDR_BITS  = 8,
  parameter int PAGE_BYTES = 32,
  parameter int CLK_DIV    = 2,
  parameter int MAX_RETRY  = 8,
  parameter int DLY_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] offset,
  input  logic [IDX_W-1:0] count,
  input  logic [DLY_W-1:0] wcDelay,
  output logic             dataReq,
  input  logic [15:0]      wrData,
  output logic             busy,
  output logic             done,
  output logic             fail,
  output logic             spiClk,
  output logic             spiCsN,
  output logic             spiMosi,
  input  logic             spiMiso
);
  linkCmd_t   cmd;
  logic       linkDone;
  logic [7:0] rxByte;

  epw_ctrl #(
    .WORD_SIZE(WORD_SIZE), .IDX_W(IDX_W), .OPC_BITS(OPC_BITS),
    .ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES),
    .MAX_RETRY(MAX_RETRY), .DLY_W(DLY_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .offset(offset), .count(count),
    .wcDelay(wcDelay), .dataReq(dataReq), .wrData(wrData), .busy(busy),
    .done(done), .fail(fail), .cmd(cmd), .linkDone(linkDone), .rxByte(rxByte)
  );

  epw_link #(.CLK_DIV(CLK_DIV)) u_link (
    .clk(clk), .rstN(rstN), .cmd(cmd), .linkDone(linkDone), .rxByte(rxByte),
    .spiClk(spiClk), .spiCsN(spiCsN), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  assert_req_inside_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    dataReq |-> !spiCsN);
  assert_done_deselected_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> spiCsN);
endmodule

// File: tb/eeprom_page_writer_tb.sv
module eeprom_page_writer_tb;
  localparam int WORDS = 256;
  localparam int MAXR  = 8;
  localparam int DIV   = 2;
  localparam int PGW   = 16;
  localparam int NVEC  = 12;

  typedef struct packed { int off; int cnt; int busyN; int wc; int tag; } vec_t;
  localparam vec_t VECS [NVEC] = '{
    '{3, 2, 0, 10, 6}, '{14, 4, 0, 5, 8}, '{130, 1, 2, 0, 5},
    '{255, 1, 0, 3, 6}, '{250, 6, 0, 3, 7}, '{256, 1, 0, 3, 1},
    '{10, 0, 0, 3, 1}, '{250, 7, 0, 3, 1}, '{40, 2, 8, 3, 3},
    '{40, 2, 7, 3, 2}, '{120, 10, 0, 4, 8}, '{0, 17, 1, 2, 4}
  };

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [15:0] offset = '0, count = '0, wcDelay = '0;
  logic dataReq, busy, done, fail, spiClk, spiCsN, spiMosi;
  logic spiMiso = 1'b0;
  logic [15:0] wrData;

  int checks = 0, errors = 0, cyc = 0, reqCnt = 0, reqBase = 0;
  int segCnt = 0, logLen = 0, segStart = 0, bitCnt = 0, statusPolls = 0;
  int lastRiseCyc = 0, pollBase = 0, busyPlan = 0;
  logic segOpen = 1'b0;
  logic [7:0] curByte = '0;
  logic [7:0] byteLog [0:511];
  int segLen [0:127];
  logic [7:0] expLog [0:255];
  int expSegLen [0:63];
  int expLen, expSegCnt, expReq;
  bit expFail;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always_ff @(posedge clk) if (dataReq) reqCnt <= reqCnt + 1;

  function automatic logic [15:0] wordOf(int k);
    return {8'(k * 7 + 49), 8'(k ^ 165)};
  endfunction
  assign wrData = wordOf(reqCnt - reqBase);

  eeprom_page_writer u_dut (
    .clk(clk), .rstN(rstN), .start(start), .offset(offset), .count(count),
    .wcDelay(wcDelay), .dataReq(dataReq), .wrData(wrData), .busy(busy),
    .done(done), .fail(fail), .spiClk(spiClk), .spiCsN(spiCsN),
    .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  // memory stub: logs each select window, answers status reads
  always @(negedge spiCsN) begin
    segOpen = 1'b1; bitCnt = 0; segStart = logLen;
  end
  always @(posedge spiClk) if (!spiCsN) begin
    curByte = {curByte[6:0], spiMosi};
    bitCnt++;
    if (bitCnt % 8 == 0 && logLen < 512) begin
      byteLog[logLen] = curByte; logLen++;
    end
  end
  always @(negedge spiClk) if (!spiCsN) begin
    logic [7:0] st;
    st = ((statusPolls - pollBase) < busyPlan) ? 8'h03 : 8'h02;
    if (bitCnt >= 8 && bitCnt < 16 && byteLog[segStart] == 8'h05) spiMiso = st[15 - bitCnt];
    else spiMiso = 1'b0;
  end
  always @(posedge spiCsN) if (segOpen) begin
    segOpen = 1'b0; lastRiseCyc = cyc;
    if (logLen > segStart && segCnt < 128) begin
      segLen[segCnt] = logLen - segStart; segCnt++;
      if (byteLog[segStart] == 8'h05) statusPolls++;
    end
  end

  function automatic string tagName(int t);
    case (t)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pushB(logic [7:0] b);
    expLog[expLen] = b; expLen++;
  endtask
  task automatic closeSeg(int n);
    expSegLen[expSegCnt] = n; expSegCnt++;
  endtask

  task automatic buildExp(int off, int cnt, int busyN);
    int w, rem, k, b, n;
    logic [15:0] d;
    bit first;
    expLen = 0; expSegCnt = 0; expFail = 0; expReq = 0;
    if (off >= WORDS || cnt == 0 || cnt > WORDS - off) begin expFail = 1; return; end
    w = off; rem = cnt; k = 0; first = 1;
    while (rem > 0) begin
      b = first ? busyN : 0; first = 0;
      n = (b >= MAXR) ? MAXR : b + 1;
      for (int i = 0; i < n; i++) begin pushB(8'h05); pushB(8'h00); closeSeg(2); end
      if (b >= MAXR) begin expFail = 1; return; end
      pushB(8'h06); closeSeg(1);
      pushB((w >= 128) ? 8'h0A : 8'h02); pushB(8'(w * 2)); n = 2;
      do begin
        d = wordOf(k); pushB(d[7:0]); pushB(d[15:8]); n += 2;
        k++; w++; rem--; expReq++;
      end while (rem > 0 && (w % PGW) != 0);
      closeSeg(n);
    end
  endtask

  task automatic idleChecks(string req);
    check(spiCsN == 1'b1, req, "select high", int'(spiCsN), 1);
    check(spiClk == 1'b0, req, "clock low", int'(spiClk), 0);
    check(spiMosi == 1'b0, req, "data line low", int'(spiMosi), 0);
    check(busy == 1'b0, req, "busy low", int'(busy), 0);
    check(done == 1'b0 && fail == 1'b0, req, "done/fail low", int'({done, fail}), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog expired: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    idleChecks("R11");
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    idleChecks("R11");

    for (int v = 0; v < NVEC; v++) begin
      int segBase, logBase, waited, doneCyc, gap, bad, firstBad, actB, expB;
      bit seen, failSeen;
      buildExp(VECS[v].off, VECS[v].cnt, VECS[v].busyN);
      pollBase = statusPolls; busyPlan = VECS[v].busyN;
      reqBase = reqCnt; segBase = segCnt; logBase = logLen;
      offset = 16'(VECS[v].off); count = 16'(VECS[v].cnt); wcDelay = 16'(VECS[v].wc);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      seen = 0; failSeen = 0; waited = 0; doneCyc = 0;
      while (!seen && waited < 40000) begin
        if (done) begin seen = 1; failSeen = fail; doneCyc = cyc; end
        else begin @(negedge clk); waited++; end
      end
      check(seen, tagName(VECS[v].tag), "done reached", int'(seen), 1);
      check(failSeen == expFail, expFail ? tagName(VECS[v].tag) : "R12",
            "fail flag", int'(failSeen), int'(expFail));
      repeat (3) @(negedge clk);
      check(segCnt - segBase == expSegCnt, tagName(VECS[v].tag), "select windows",
            segCnt - segBase, expSegCnt);
      bad = 0; firstBad = -1; actB = 0; expB = 0;
      for (int i = 0; i < expSegCnt; i++)
        if (segBase + i < segCnt && segLen[segBase + i] != expSegLen[i]) bad++;
      for (int i = 0; i < expLen; i++)
        if (logBase + i >= logLen || byteLog[logBase + i] !== expLog[i]) begin
          if (firstBad < 0) begin
            firstBad = i; expB = expLog[i];
            actB = (logBase + i < logLen) ? int'(byteLog[logBase + i]) : -1;
          end
          bad++;
        end
      check(bad == 0 && (logLen - logBase) == expLen, tagName(VECS[v].tag),
            $sformatf("byte stream (index %0d)", firstBad), actB, expB);
      check(reqCnt - reqBase == expReq, "R7", "data requests", reqCnt - reqBase, expReq);
      if (!expFail) begin
        gap = doneCyc - lastRiseCyc;
        check(gap >= VECS[v].wc && gap <= VECS[v].wc + DIV + 6, "R10",
              "select-high cycles before done", gap, VECS[v].wc);
      end
      check(spiCsN && !spiClk && !spiMosi, "R9", "link parked after run",
            int'({spiCsN, spiClk, spiMosi}), 4);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule